// File: doc/BRIEF.md
# Sorted-Request Grant Allocator

This block ranks a slot's worth of switch requests so that no more than K of them reach any one outlet. Its input is a vector of N request records that an upstream sorter has already ordered by destination. Each record has an activity bit, a destination outlet and the number of the port that issued it. Records aimed at the same outlet therefore sit on neighbouring positions, and idle records come after every active one. The block walks the vector and keeps a running count that restarts at the start of each run of same-destination active records. An idle record never advances the count.

For every position the block reports a grant number, a won flag and a routing index. The routing index picks one of the K links into the output queue. The same results are also returned a second way, re-indexed by the issuing port, so that each port reads its own answer at its own index. Results are registered: a valid strobe with the request vector gives a result-valid strobe one cycle later. The results then stay in place until the next strobe.

Top module: `sorted_grant_alloc`

## Requirements
- R1: While rst_ni is low, and after it until the first valid_i, valid_o, win_o and ack_win_o are all zero.
- R2: valid_o is high in exactly the cycle after a cycle with valid_i high. It is low after any cycle with valid_i low.
- R3: The first active record of a run of adjacent active records with the same destination gets grant 0. Each later record of the run gets the previous grant plus one, in position order.
- R4: Within a run, records after the first K get grant value K (saturated) and win_o low. At most K records per outlet win.
- R5: An idle record (act bit 0) gets grant K and win_o low, and takes no grant number from any run.
- R6: win_o of a position is 1 exactly when its grant is at most K-1. Grant fields are log2(K)+1 bits wide; position i sits at bits [i*GW +: GW].
- R7: ridx_o of a winning position holds the low log2(K) bits of its grant (the link number, 0..K-1). A losing position has ridx_o zero.
- R8: ack_win_o[s] and ack_grant_o field s equal win and grant of the active record whose source is s. A port with no active record reads win 0 and grant K.
- R9: While valid_i is low, all result outputs hold their last values, whatever the other inputs do.
- R10: Adjacent active records with different destinations belong to different runs. Each of them starts again at grant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request vector valid this cycle |
| act_i | input | N | Activity bit per position |
| dst_i | input | N*AW | Destination outlet per position, AW=log2(N) |
| src_i | input | N*AW | Issuing port per position |
| valid_o | output | 1 | Results valid, one cycle after valid_i |
| grant_o | output | N*GW | Grant number per position, GW=log2(K)+1 |
| win_o | output | N | Request won per position |
| ridx_o | output | N*RW | Link index per position, RW=max(1,log2(K)) |
| ack_win_o | output | N | Won flag indexed by issuing port |
| ack_grant_o | output | N*GW | Grant number indexed by issuing port |

## Verification
The assertions assume three things about the inputs. The records are sorted with idle entries last, the source numbers of the active records are distinct, and equal destinations are contiguous. Without these, the balance between winners and port acknowledgements and the per-run cap would not hold. The bench builds each vector from an ordered destination list with idle entries padded at the tail. It assigns sources by an odd-stride permutation of the port numbers, so every source appears exactly once.

// File: rtl/sga_pkg.sv
package sga_pkg;

  // next grant number along the sorted vector
  function automatic int grant_next(int prev, int k, logic act, logic seg_start);
    if (!act) return k;
    if (seg_start) return 0;
    if (prev >= k) return k;
    return prev + 1;
  endfunction

endpackage

// File: rtl/sga_seg_count.sv
module sga_seg_count #(
  parameter int N  = 8,
  parameter int K  = 2,
  parameter int AW = 3,
  parameter int GW = 2
) (
  input  logic [N-1:0]    act_i,
  input  logic [N*AW-1:0] dst_i,
  output logic [N*GW-1:0] grant_o
);
  logic [GW-1:0] g [N];
  logic [N-1:0]  seg_start;

  for (genvar i = 0; i < N; i++) begin : g_pos
    if (i == 0) begin : g_first
      assign seg_start[i] = 1'b1;
      assign g[i] = GW'(sga_pkg::grant_next(0, K, act_i[i], seg_start[i]));
    end else begin : g_rest
      assign seg_start[i] = !act_i[i-1] ||
                            (dst_i[i*AW +: AW] != dst_i[(i-1)*AW +: AW]);
      assign g[i] = GW'(sga_pkg::grant_next(int'(g[i-1]), K, act_i[i], seg_start[i]));
    end
    assign grant_o[i*GW +: GW] = g[i];
  end
endmodule

// File: rtl/sga_ack_map.sv
module sga_ack_map #(
  parameter int N  = 8,
  parameter int K  = 2,
  parameter int AW = 3,
  parameter int GW = 2
) (
  input  logic [N-1:0]    act_i,
  input  logic [N*AW-1:0] src_i,
  input  logic [N*GW-1:0] grant_i,
  input  logic [N-1:0]    win_i,
  output logic [N*GW-1:0] ack_grant_o,
  output logic [N-1:0]    ack_win_o
);
  for (genvar s = 0; s < N; s++) begin : g_src
    logic [GW-1:0] ag;
    logic          aw;
    always_comb begin
      ag = GW'(K);
      aw = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (act_i[i] && (src_i[i*AW +: AW] == AW'(s))) begin
          ag = grant_i[i*GW +: GW];
          aw = win_i[i];
        end
      end
    end
    assign ack_grant_o[s*GW +: GW] = ag;
    assign ack_win_o[s]            = aw;
  end
endmodule

// File: rtl/sorted_grant_alloc.sv
module sorted_grant_alloc #(
  parameter int N = 8,
  parameter int K = 2,
  localparam int AW = (N > 1) ? $clog2(N) : 1,
  localparam int GW = $clog2(K) + 1,
  localparam int RW = (K > 1) ? $clog2(K) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [N-1:0]    act_i,
  input  logic [N*AW-1:0] dst_i,
  input  logic [N*AW-1:0] src_i,
  output logic            valid_o,
  output logic [N*GW-1:0] grant_o,
  output logic [N-1:0]    win_o,
  output logic [N*RW-1:0] ridx_o,
  output logic [N-1:0]    ack_win_o,
  output logic [N*GW-1:0] ack_grant_o
);
  logic [N*GW-1:0] grant_d, ack_grant_d;
  logic [N-1:0]    win_d, ack_win_d;
  logic [N*RW-1:0] ridx_d;

  sga_seg_count #(.N(N), .K(K), .AW(AW), .GW(GW)) u_count (
    .act_i   (act_i),
    .dst_i   (dst_i),
    .grant_o (grant_d)
  );

  for (genvar i = 0; i < N; i++) begin : g_win
    assign win_d[i] = grant_d[i*GW +: GW] < GW'(K);
    assign ridx_d[i*RW +: RW] = win_d[i] ? grant_d[i*GW +: RW] : '0;
  end

  sga_ack_map #(.N(N), .K(K), .AW(AW), .GW(GW)) u_ack (
    .act_i       (act_i),
    .src_i       (src_i),
    .grant_i     (grant_d),
    .win_i       (win_d),
    .ack_grant_o (ack_grant_d),
    .ack_win_o   (ack_win_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      grant_o     <= '0;
      win_o       <= '0;
      ridx_o      <= '0;
      ack_win_o   <= '0;
      ack_grant_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        grant_o     <= grant_d;
        win_o       <= win_d;
        ridx_o      <= ridx_d;
        ack_win_o   <= ack_win_d;
        ack_grant_o <= ack_grant_d;
      end
    end
  end
endmodule

// File: rtl/sga_checker.sv
module sga_checker #(
  parameter int N  = 8,
  parameter int K  = 2,
  parameter int AW = 3,
  parameter int GW = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [N-1:0]    act_i,
  input logic [N*AW-1:0] dst_i,
  input logic            valid_o,
  input logic [N*GW-1:0] grant_o,
  input logic [N-1:0]    win_o,
  input logic [N-1:0]    ack_win_o
);
  // full_run[i]: positions i-K..i all active with one destination
  logic [N-1:0] full_run;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      full_run[i] = (i >= K);
      for (int j = 0; j <= K; j++) begin
        if (i >= K) begin
          if (!act_i[i-j] || dst_i[(i-j)*AW +: AW] != dst_i[i*AW +: AW])
            full_run[i] = 1'b0;
        end
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_HOLD_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(win_o) && $stable(grant_o)); // R9
  AST_FIRST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && act_i[0] |=> grant_o[GW-1:0] == '0); // R3
  AST_ACK_BALANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(ack_win_o) == $countones(win_o)); // R8

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_IDLE_LOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && !act_i[i] |=> !win_o[i] && grant_o[i*GW +: GW] == GW'(K)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && full_run[i] |=> !win_o[i]); // R4
  end
endmodule

bind sorted_grant_alloc sga_checker #(.N(N), .K(K), .AW(AW), .GW(GW)) u_sga_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .act_i     (act_i),
  .dst_i     (dst_i),
  .valid_o   (valid_o),
  .grant_o   (grant_o),
  .win_o     (win_o),
  .ack_win_o (ack_win_o)
);

// File: tb/tb_sorted_grant_alloc.sv
module tb_sorted_grant_alloc;
  localparam int N = 8;
  localparam int K = 2;
  localparam int AW = $clog2(N);
  localparam int GW = $clog2(K) + 1;
  localparam int RW = (K > 1) ? $clog2(K) : 1;
  localparam int CLK_PERIOD = 10;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [N-1:0]    act_i = '0;
  logic [N*AW-1:0] dst_i = '0;
  logic [N*AW-1:0] src_i = '0;
  logic            valid_o;
  logic [N*GW-1:0] grant_o;
  logic [N-1:0]    win_o;
  logic [N*RW-1:0] ridx_o;
  logic [N-1:0]    ack_win_o;
  logic [N*GW-1:0] ack_grant_o;

  int n_tests = 0;
  int n_fail  = 0;
  int t_act [N];
  int t_dst [N];
  int t_src [N];
  int e_grant [N];
  int e_agrant [N];
  int e_awin [N];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sorted_grant_alloc #(.N(N), .K(K)) dut (
    .clk_i, .rst_ni, .valid_i, .act_i, .dst_i, .src_i,
    .valid_o, .grant_o, .win_o, .ridx_o, .ack_win_o, .ack_grant_o
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference: per-destination count of earlier active requests
  task automatic model();
    int cnt [N];
    for (int d = 0; d < N; d++) cnt[d] = 0;
    for (int s = 0; s < N; s++) begin e_agrant[s] = K; e_awin[s] = 0; end
    for (int i = 0; i < N; i++) begin
      if (t_act[i] == 0) e_grant[i] = K;
      else begin
        e_grant[i] = (cnt[t_dst[i]] < K) ? cnt[t_dst[i]] : K;
        cnt[t_dst[i]]++;
        e_agrant[t_src[i]] = e_grant[i];
        e_awin[t_src[i]]   = (e_grant[i] < K) ? 1 : 0;
      end
    end
  endtask

  task automatic check_outputs(string tag);
    for (int i = 0; i < N; i++) begin
      int w = (e_grant[i] < K) ? 1 : 0;
      check({tag, " R3/R4/R5 grant"}, int'(grant_o[i*GW +: GW]), e_grant[i]);
      check({tag, " R6 win"}, int'(win_o[i]), w);
      check({tag, " R7 ridx"}, int'(ridx_o[i*RW +: RW]), w ? e_grant[i] % K : 0);
      check({tag, " R8 ack_win"}, int'(ack_win_o[i]), e_awin[i]);
      check({tag, " R8 ack_grant"}, int'(ack_grant_o[i*GW +: GW]), e_agrant[i]);
    end
  endtask

  task automatic apply(string tag, int rot);
    for (int i = 0; i < N; i++) begin
      t_src[i] = (i * 3 + rot) % N;
      act_i[i] = t_act[i][0];
      dst_i[i*AW +: AW] = AW'(t_dst[i]);
      src_i[i*AW +: AW] = AW'(t_src[i]);
    end
    model();
    @(negedge clk_i);
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({tag, " R2 valid_o high"}, int'(valid_o), 1);
    check_outputs(tag);
    @(negedge clk_i);
    check({tag, " R2 valid_o low"}, int'(valid_o), 0);
  endtask

  task automatic set_vec(int d [N], int nact);
    for (int i = 0; i < N; i++) begin
      t_act[i] = (i < nact) ? 1 : 0;
      t_dst[i] = (i < nact) ? d[i] : 0;
    end
  endtask

  task automatic test_reset();
    check("R1 valid_o", int'(valid_o), 0);
    check("R1 win_o", int'(win_o), 0);
    check("R1 ack_win_o", int'(ack_win_o), 0);
  endtask

  task automatic test_all_idle();
    int d [N] = '{0, 0, 0, 0, 0, 0, 0, 0};
    set_vec(d, 0);
    apply("idle R5", 1);
  endtask

  task automatic test_distinct();
    int d [N] = '{0, 1, 2, 3, 4, 5, 6, 7};
    set_vec(d, N);
    apply("distinct R10", 2);
  endtask

  task automatic test_one_outlet();
    int d [N] = '{5, 5, 5, 5, 5, 5, 5, 5};
    set_vec(d, N);
    apply("hotspot R4", 5);
  endtask

  task automatic test_mixed();
    int d [N] = '{0, 0, 0, 2, 3, 3, 0, 0};
    set_vec(d, 6);
    apply("mixed R3/R5", 0);
  endtask

  task automatic test_pairs();
    int d [N] = '{1, 1, 4, 4, 6, 6, 7, 7};
    set_vec(d, N);
    apply("pairs R10", 7);
  endtask

  task automatic test_hold();
    int d [N] = '{2, 2, 2, 6, 6, 6, 6, 0};
    set_vec(d, 7);
    apply("pre-hold", 3);
    // change inputs with valid_i low; results must not move
    act_i = '1;
    dst_i = '0;
    src_i = ~src_i;
    repeat (3) @(negedge clk_i);
    check_outputs("hold R9");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    test_reset();
    test_all_idle();
    test_distinct();
    test_one_outlet();
    test_mixed();
    test_pairs();
    test_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule